// File: doc/BRIEF.md
# Card Bus Clock Divider Controller

This block derives the card bus clock from the input clock. The divide ratio is a power of two and can be selected. The block also supplies the divider field code and the data-timeout exponent code that belong to the selected ratio. A host sequencer asks for a new ratio, or for the clock to stop, through a single-cycle request. The block gives one response per request, one cycle later: accepted, busy or parameter error.

An accepted change follows a fixed order. The block first marks the clock disabled. It then lets any high phase in progress run to its end, loads the new ratio while the output is low, and starts the clock again. A stop request takes the same path but leaves the clock stopped. The block keeps track of the ratio in use. A request for that ratio while the clock runs is accepted and nothing changes. A change is refused while the card command engine reports busy, or while a change is still in progress.

The input clock runs at twice the nominal base rate. Each half-period of `card_clk` therefore lasts `ratio` input cycles.

Top module: `sdclk_ctrl`

## Requirements
- R1: Ratios 1, 2, 4, 8, 16, 32, 64, 128, 256 and 512, given as their binary value on `req_ratio`, are accepted when idle. `cur_ratio` then reports the new ratio once `clk_en` returns high.
- R2: `div_code` is 0xFF for ratio 1 and 0x00 for ratio 2. Ratios 4 through 512 give a one-hot code: 0x01 for ratio 4, with the set bit moving up one place for each doubling, up to 0x80 for ratio 512.
- R3: `tmo_code` is 0xE0 for ratios 1 and 2. For ratios 4 to 256 it falls by 0x10 per doubling, from 0xD0 to 0x70. For ratio 512 it stays at 0x70.
- R4: While the clock runs, every high phase of `card_clk` lasts exactly `cur_ratio` input clock cycles, and no shorter pulse appears when the ratio changes or the clock stops.
- R5: A request for the ratio already in use while `clk_en` is high is answered OK. `clk_en` stays high and the settings do not change, even when `cmd_busy` is set.
- R6: A change request is answered BUSY, and the settings are left as they were, in two cases: while `cmd_busy` is high, or while a previous change or stop has not yet completed.
- R7: On an accepted change, `clk_en` goes low in the response cycle. The new divider is loaded only while `card_clk` is low and `clk_en` is low. `clk_en` returns high one cycle after the load.
- R8: An accepted stop request drives `clk_en` low. `card_clk` finishes any high phase, then stays low and never rises while `clk_en` is low. A stop request while `cmd_busy` is high is answered BUSY.
- R9: A `req_ratio` that is zero or not a single power of two up to 512 is answered with a parameter error, and the settings do not change. The parameter check takes precedence over the same-ratio check, which takes precedence over the busy check.
- R10: When a change request and a stop request arrive in the same cycle, the change is handled and the stop request is dropped.
- R11: After reset, `clk_en` and `card_clk` are low, `cur_ratio` is 512, `div_code` is 0x80, `tmo_code` is 0x70 and `rsp_valid` is low.
- R12: `rsp_valid` pulses for one cycle, one clock after each request. `rsp_code` is 0 for OK, 1 for BUSY and 2 for a parameter error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, twice the base rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Ratio change request strobe |
| req_ratio | input | 10 | Requested divide ratio as a binary value |
| off_req | input | 1 | Clock stop request strobe |
| cmd_busy | input | 1 | Card command engine busy |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 OK, 1 BUSY, 2 parameter error |
| clk_en | output | 1 | Clock-enabled state |
| card_clk | output | 1 | Divided card bus clock |
| div_code | output | 8 | Divider field code of the current ratio |
| tmo_code | output | 8 | Data-timeout exponent code of the current ratio |
| cur_ratio | output | 10 | Divide ratio currently loaded |

## Verification
Two things can fall in the same cycle. One is a change request and a stop request together. The other is a new change request arriving while the drain of an earlier change has not finished. The first case is provoked by raising `req_valid` and `off_req` together; the bench judges it by `clk_en` coming back high at the requested ratio, not staying low. The second case is provoked by requesting a fast ratio while the slowest ratio's clock is in its high phase, then sending another request at once; that request must be answered BUSY, and the first change must still complete. Random requests mix all ten ratios, invalid values, busy pulses and stops, and each is checked against a bench model of the expected code and settings.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_LOAD  = 2'd3
    } sdclk_st_e;

    typedef enum logic [1:0] {
        RSP_OK    = 2'd0,
        RSP_BUSY  = 2'd1,
        RSP_PARAM = 2'd2
    } sdclk_rsp_e;

endpackage

// File: rtl/sdclk_ratio_dec.sv
module sdclk_ratio_dec #(
    parameter int unsigned MAX_LOG = 9,
    parameter int unsigned RATIO_W = MAX_LOG + 1,
    parameter int unsigned IDX_W   = $clog2(MAX_LOG + 1)
) (
    input  logic [RATIO_W-1:0] ratio,
    output logic               ok,
    output logic [IDX_W-1:0]   idx
);

    logic [IDX_W-1:0] part [RATIO_W];

    for (genvar g = 0; g < RATIO_W; g++) begin : g_bit
        assign part[g] = ratio[g] ? IDX_W'(g) : '0;
    end

    always_comb begin
        ok  = $onehot(ratio);
        idx = '0;
        for (int i = 0; i < RATIO_W; i++) begin
            idx = idx | part[i];
        end
    end

endmodule

// File: rtl/sdclk_code_map.sv
module sdclk_code_map #(
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned TMO_W     = 8,
    parameter logic [7:0]  DIV_FULL  = 8'hFF,
    parameter logic [7:0]  TMO_TOP   = 8'hE0,
    parameter logic [7:0]  TMO_FLOOR = 8'h70,
    parameter logic [7:0]  TMO_STEP  = 8'h10,
    parameter int unsigned FLOOR_IDX = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [DIV_W-1:0] div_code,
    output logic [TMO_W-1:0] tmo_code
);

    always_comb begin
        if (idx == IDX_W'(0)) begin
            div_code = DIV_W'(DIV_FULL);
        end else if (idx == IDX_W'(1)) begin
            div_code = '0;
        end else begin
            div_code = DIV_W'(1) << (idx - IDX_W'(2));
        end

        if (idx <= IDX_W'(1)) begin
            tmo_code = TMO_W'(TMO_TOP);
        end else if (idx >= IDX_W'(FLOOR_IDX)) begin
            tmo_code = TMO_W'(TMO_FLOOR);
        end else begin
            tmo_code = TMO_W'(TMO_TOP) - TMO_W'(TMO_STEP) * TMO_W'(idx - IDX_W'(1));
        end
    end

endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
    import sdclk_pkg::*;
#(
    parameter int unsigned MAX_LOG = 9,
    parameter int unsigned RST_LOG = 9,
    parameter int unsigned CODE_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [MAX_LOG:0]     req_ratio,
    input  logic                 off_req,
    input  logic                 cmd_busy,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_code,
    output logic                 clk_en,
    output logic                 card_clk,
    output logic [CODE_W-1:0]    div_code,
    output logic [CODE_W-1:0]    tmo_code,
    output logic [MAX_LOG:0]     cur_ratio
);

    localparam int unsigned RATIO_W = MAX_LOG + 1;
    localparam int unsigned IDX_W   = $clog2(MAX_LOG + 1);

    typedef struct packed {
        sdclk_st_e          st;
        logic               en;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   pend;
        logic               restart;
        logic [RATIO_W-1:0] cnt;
        logic               sclk;
        logic               rsp_v;
        sdclk_rsp_e         rsp;
    } sdclk_regs_t;

    sdclk_regs_t r_d, r_q;

    logic               dec_ok;
    logic [IDX_W-1:0]   dec_idx;
    logic [RATIO_W-1:0] lim_m1;
    logic               wrap;
    logic               busy_any;

    sdclk_ratio_dec #(
        .MAX_LOG (MAX_LOG),
        .RATIO_W (RATIO_W),
        .IDX_W   (IDX_W)
    ) i_dec (
        .ratio (req_ratio),
        .ok    (dec_ok),
        .idx   (dec_idx)
    );

    sdclk_code_map #(
        .IDX_W (IDX_W),
        .DIV_W (CODE_W),
        .TMO_W (CODE_W)
    ) i_map (
        .idx      (r_q.idx),
        .div_code (div_code),
        .tmo_code (tmo_code)
    );

    assign lim_m1   = (RATIO_W'(1) << r_q.idx) - RATIO_W'(1);
    assign wrap     = (r_q.cnt == lim_m1);
    assign busy_any = cmd_busy || (r_q.st == ST_DRAIN) || (r_q.st == ST_LOAD);

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;
        r_d.rsp   = RSP_OK;

        // clock generator and change sequencer
        unique case (r_q.st)
            ST_RUN: begin
                if (wrap) begin
                    r_d.cnt  = '0;
                    r_d.sclk = ~r_q.sclk;
                end else begin
                    r_d.cnt = r_q.cnt + RATIO_W'(1);
                end
            end
            ST_DRAIN: begin
                if (!r_q.sclk || wrap) begin
                    r_d.sclk = 1'b0;
                    r_d.cnt  = '0;
                    if (r_q.restart) begin
                        r_d.idx = r_q.pend;
                        r_d.st  = ST_LOAD;
                    end else begin
                        r_d.st = ST_OFF;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + RATIO_W'(1);
                end
            end
            ST_LOAD: begin
                r_d.st = ST_RUN;
                r_d.en = 1'b1;
            end
            default: begin
            end
        endcase

        // request handling
        if (req_valid) begin
            r_d.rsp_v = 1'b1;
            if (!dec_ok) begin
                r_d.rsp = RSP_PARAM;
            end else if (r_q.en && (dec_idx == r_q.idx)) begin
                r_d.rsp = RSP_OK;
            end else if (busy_any) begin
                r_d.rsp = RSP_BUSY;
            end else begin
                r_d.rsp     = RSP_OK;
                r_d.en      = 1'b0;
                r_d.pend    = dec_idx;
                r_d.restart = 1'b1;
                r_d.st      = ST_DRAIN;
            end
        end else if (off_req) begin
            r_d.rsp_v = 1'b1;
            if (busy_any) begin
                r_d.rsp = RSP_BUSY;
            end else if (r_q.st != ST_OFF) begin
                r_d.en      = 1'b0;
                r_d.restart = 1'b0;
                r_d.st      = ST_DRAIN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_OFF;
            r_q.en      <= 1'b0;
            r_q.idx     <= IDX_W'(RST_LOG);
            r_q.pend    <= IDX_W'(RST_LOG);
            r_q.restart <= 1'b0;
            r_q.cnt     <= '0;
            r_q.sclk    <= 1'b0;
            r_q.rsp_v   <= 1'b0;
            r_q.rsp     <= RSP_OK;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid = r_q.rsp_v;
    assign rsp_code  = r_q.rsp;
    assign clk_en    = r_q.en;
    assign card_clk  = r_q.sclk;
    assign cur_ratio = RATIO_W'(1) << r_q.idx;

endmodule

// File: rtl/sdclk_ctrl_chk.sv
module sdclk_ctrl_chk #(
    parameter int unsigned MAX_LOG = 9,
    parameter int unsigned CODE_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [MAX_LOG:0]  req_ratio,
    input logic              rsp_valid,
    input logic [1:0]        rsp_code,
    input logic              clk_en,
    input logic              card_clk,
    input logic [CODE_W-1:0] div_code,
    input logic [CODE_W-1:0] tmo_code,
    input logic [MAX_LOG:0]  cur_ratio
);

    AST_TMO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (div_code == 8'hFF || div_code == 8'h00) |-> tmo_code == 8'hE0); // R3

    AST_SAME_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid) && $past(clk_en) && $past(req_ratio) == $past(cur_ratio))
        |-> (clk_en && rsp_code == 2'd0 && $stable(div_code))); // R5

    AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd1 && $past(clk_en)) |-> ($stable(div_code) && clk_en)); // R6

    AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_code) |-> (!card_clk && !clk_en)); // R7

    AST_RISE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> $past(clk_en)); // R8

    AST_PARAM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd2 && $past(clk_en)) |-> ($stable(div_code) && clk_en)); // R9

endmodule

bind sdclk_ctrl sdclk_ctrl_chk #(
    .MAX_LOG (MAX_LOG),
    .CODE_W  (CODE_W)
) i_sdclk_ctrl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ratio (req_ratio),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .clk_en    (clk_en),
    .card_clk  (card_clk),
    .div_code  (div_code),
    .tmo_code  (tmo_code),
    .cur_ratio (cur_ratio)
);

// File: tb/test_sdclk_ctrl.sv
module test_sdclk_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [9:0] req_ratio = '0;
    logic       off_req = 1'b0;
    logic       cmd_busy = 1'b0;
    logic       rsp_valid;
    logic [1:0] rsp_code;
    logic       clk_en;
    logic       card_clk;
    logic [7:0] div_code;
    logic [7:0] tmo_code;
    logic [9:0] cur_ratio;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit m_en = 0;
    int m_ratio = 512;

    always #5 clk = ~clk;

    sdclk_ctrl i_sdclk_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ratio(req_ratio),
        .off_req(off_req), .cmd_busy(cmd_busy), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .clk_en(clk_en), .card_clk(card_clk),
        .div_code(div_code), .tmo_code(tmo_code), .cur_ratio(cur_ratio)
    );

    function automatic int lg(input int r);
        for (int i = 0; i < 10; i++) if (r == (1 << i)) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_div(input int r);
        int k = lg(r);
        if (k == 0) return 8'hFF;
        if (k == 1) return 8'h00;
        return 8'(1 << (k - 2));
    endfunction

    function automatic logic [7:0] exp_tmo(input int r);
        int k = lg(r);
        if (k <= 1) return 8'hE0;
        if (k >= 8) return 8'h70;
        return 8'(8'hE0 - 16 * (k - 1));
    endfunction

    function automatic int exp_code(input int r, input bit busy, input bit off);
        if (off) return busy ? 1 : 0;
        if (lg(r) < 0) return 2;
        if (m_en && r == m_ratio) return 0;
        if (busy) return 1;
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R4: every high phase lasts cur_ratio cycles
    int hi_len = 0;
    int hi_ref = 0;
    bit prev_clk = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (card_clk) begin
                if (!prev_clk) begin
                    hi_len = 1;
                    hi_ref = int'(cur_ratio);
                end else begin
                    hi_len++;
                end
            end else if (prev_clk) begin
                check(hi_len == hi_ref, "R4 high phase", hi_len, hi_ref);
            end
            prev_clk = card_clk;
        end
    end

    task automatic send(input int r, input bit busy, input bit off, input bit chg, output int code);
        @(negedge clk);
        req_valid = chg;
        req_ratio = 10'(r);
        off_req   = off;
        cmd_busy  = busy;
        @(negedge clk);
        req_valid = 1'b0;
        off_req   = 1'b0;
        cmd_busy  = 1'b0;
        check(rsp_valid == 1'b1, "R12 rsp_valid", int'(rsp_valid), 1);
        code = int'(rsp_code);
    endtask

    task automatic wait_en();
        for (int i = 0; i < 3000 && !clk_en; i++) @(negedge clk);
    endtask

    task automatic wait_stop();
        for (int i = 0; i < 3000 && card_clk; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_settings(input string tag);
        check(clk_en == m_en, {tag, " clk_en"}, int'(clk_en), int'(m_en));
        check(int'(cur_ratio) == m_ratio, {tag, " cur_ratio R1"}, int'(cur_ratio), m_ratio);
        check(div_code == exp_div(m_ratio), {tag, " div_code R2"}, int'(div_code), int'(exp_div(m_ratio)));
        check(tmo_code == exp_tmo(m_ratio), {tag, " tmo_code R3"}, int'(tmo_code), int'(exp_tmo(m_ratio)));
    endtask

    task automatic apply(input int r, input bit busy, input bit off, input string tag);
        int code;
        int e = exp_code(r, busy, off);
        bit act_chg = !off && e == 0 && !(m_en && r == m_ratio);
        bit act_off = off && e == 0;
        send(r, busy, off, !off, code);
        check(code == e, {tag, " rsp_code"}, code, e);
        if (act_chg) begin
            check(clk_en == 1'b0, {tag, " R7 en drop"}, int'(clk_en), 0);
            wait_en();
            m_en = 1;
            m_ratio = r;
        end else if (act_off) begin
            check(clk_en == 1'b0, {tag, " R8 en drop"}, int'(clk_en), 0);
            wait_stop();
            m_en = 0;
            check(card_clk == 1'b0, {tag, " R8 stopped low"}, int'(card_clk), 0);
        end
        check_settings(tag);
    endtask

    initial begin
        int code;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R11 reset state
        check(clk_en == 0 && card_clk == 0, "R11 reset clock", int'({clk_en, card_clk}), 0);
        check(cur_ratio == 10'd512, "R11 reset ratio", int'(cur_ratio), 512);
        check(div_code == 8'h80 && tmo_code == 8'h70, "R11 reset codes", int'({div_code, tmo_code}), 16'h8070);
        check(rsp_valid == 0, "R11 no response", int'(rsp_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1/R2/R3 sweep across all ratios
        for (int k = 0; k < 10; k++) apply(1 << k, 0, 0, "R1 sweep");
        for (int k = 9; k >= 0; k--) apply(1 << k, 0, 0, "R2 R3 sweep down");

        // R5 same ratio while busy
        apply(m_ratio, 1, 0, "R5 same ratio busy");
        // R6 busy change
        apply(8, 1, 0, "R6 busy change");
        // R9 invalid values, precedence over busy
        apply(0, 1, 0, "R9 zero");
        apply(3, 0, 0, "R9 non power");
        apply(1023, 1, 0, "R9 all ones");
        // R8 stop busy, stop, restart same ratio
        apply(0, 1, 1, "R8 stop busy");
        apply(0, 0, 1, "R8 stop");
        apply(0, 0, 1, "R8 stop again");
        apply(m_ratio, 0, 0, "R1 restart same ratio");

        // R10 change and stop together: change wins
        @(negedge clk);
        req_valid = 1; req_ratio = 10'd16; off_req = 1;
        @(negedge clk);
        req_valid = 0; off_req = 0;
        check(rsp_code == 2'd0, "R10 rsp", int'(rsp_code), 0);
        wait_en();
        m_en = 1; m_ratio = 16;
        check_settings("R10 change wins");

        // R6 request during drain
        apply(512, 0, 0, "R6 setup 512");
        for (int i = 0; i < 3000 && !card_clk; i++) @(negedge clk);
        send(2, 0, 0, 1, code);
        check(code == 0, "R7 accept during high", code, 0);
        send(4, 0, 0, 1, code);
        check(code == 1, "R6 busy while draining", code, 1);
        check(int'(cur_ratio) == 512, "R6 ratio held in drain", int'(cur_ratio), 512);
        wait_en();
        m_en = 1; m_ratio = 2;
        check_settings("R7 change completed");

        // random mix
        for (int it = 0; it < 80; it++) begin
            int sel = int'($urandom % 15);
            bit busy = ($urandom % 4) == 0;
            int r;
            if (sel < 10) r = 1 << sel;
            else if (sel == 10) r = 0;
            else if (sel == 11) r = 6;
            else if (sel == 12) r = 768;
            else r = int'($urandom % 1024);
            if (sel == 14) apply(0, busy, 1, "R8 random stop");
            else apply(r, busy, 0, "R1 R5 R6 R9 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule